// File: doc/BRIEF.md
# Radix-2³ delay-feedback butterfly stage

This block is one stage of a streaming single-path delay-feedback FFT/IFFT pipeline. It accepts one complex sample per valid cycle and keeps HALF samples in a feedback delay line, where HALF is half the span that the stage serves. Within each span of 2·HALF samples, the first half is a fill phase. In that phase each incoming sample is parked in the delay, and the difference left there by the previous span is sent out after its trivial rotation. The second half is the butterfly phase. Each incoming sample meets its partner from the delay: the sum goes out at once and the difference goes back into the delay.

The trivial rotations of the radix-2³ scheme are folded into the stage. Depending on the KIND parameter, a stage applies no rotation, a −j rotation over the second half of its differences, or the eighth-circle set 1, W^(N/8), −j, W^(3N/8), one value per quarter of the differences. The ±45° factors use a shift-and-add approximation of √2/2. IFFT mode conjugates every rotation. A bypass input routes samples straight through, so that a cascade can be shortened for a smaller transform length. A frame-start strobe realigns the span counter.

Top module: `sdf_r2cube_stage`

## Requirements
- R1: While rst_n is low, and until the first accepted sample after reset, o_valid is 0; o_re and o_im are 0 during reset.
- R2: Every output follows its accepted input by exactly one clock; a cycle with i_valid low gives o_valid low in the next cycle.
- R3: Each accepted non-bypass sample takes position p, which counts 0 to 2·HALF−1 and wraps. A sample carrying i_sof takes position 0, and the sample after it takes position 1.
- R4: At a position p ≥ HALF, the stage outputs a valid sample equal to the sum of the current input and the input at position p−HALF. The difference (earlier minus later) is stored for the next span.
- R5: At a position q < HALF, the output is valid only if the previous span's butterfly phase ran to completion without a misaligned i_sof. The output is then the stored difference of pair q, rotated; otherwise o_valid is 0.
- R6: With KIND=ROT_W8 and i_inv=0, the difference (a, b) of pair q is rotated according to k = 4q/HALF (integer division). k=0 gives (a, b). k=1 gives (c(a+b), c(b−a)). k=2 gives (b, −a). k=3 gives (c(b−a), −c(a+b)).
- R7: With i_inv=1, the rotations are conjugated. k=1 gives (c(a−b), c(a+b)). k=2 gives (−b, a). k=3 gives (−c(a+b), c(a−b)).
- R8: c(v) is floor((v·46340 + 32768)/65536), computed with shifts and adds. Every rotated component saturates to the internal range [−2^DW, 2^DW−1].
- R9: A sample with i_bypass=1 comes out one cycle later, sign-extended to the output width and unscaled. It does not advance the position counter, does not touch the delay line, and its i_sof has no effect.
- R10: With SCALE=1, the sum and rotated outputs are shifted right arithmetically by one bit (floor) to a width of DW; with SCALE=0 they are DW+1 bits wide.
- R11: An i_sof that arrives when the position counter is not 0 cancels the pending drain. Every fill-phase output of the span it starts is then invalid.
- R12: With KIND=ROT_MJ, the differences at q < HALF/2 pass unrotated. Those at q ≥ HALF/2 become (b, −a), or (−b, a) when i_inv=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_valid | input | 1 | Input sample is present |
| i_sof | input | 1 | Sample is the first of a span |
| i_inv | input | 1 | 1 = inverse transform (conjugated rotations) |
| i_bypass | input | 1 | Pass the sample through unprocessed |
| i_re | input | DW | Real part of input, two's complement |
| i_im | input | DW | Imaginary part of input, two's complement |
| o_valid | output | 1 | Output sample is present |
| o_re | output | DW+1, or DW when SCALE=1 | Real part of output |
| o_im | output | DW+1, or DW when SCALE=1 | Imaginary part of output |

## Verification
The assertions run on every cycle. They check that an idle input cycle gives an idle output cycle, that a bypassed sample reappears unchanged one clock later, that every butterfly-phase sample produces an output, that an unarmed fill phase stays silent, and that a frame-start strobe restarts the position count. Only the bench's scenarios can show that the numbers are right. These are the sums and differences paired across HALF samples, the quarter-by-quarter rotations in both directions, the rounding and saturation of the √2/2 products, the halving in the scaled variant, and the cancellation of a drain by a misaligned frame start.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  // Which trivial rotation a stage applies to the differences it drains
  typedef enum logic [1:0] {
    ROT_NONE = 2'd0,
    ROT_MJ   = 2'd1,
    ROT_W8   = 2'd2
  } rot_kind_e;

  // sqrt(2)/2 as a 16-bit fraction: 0xB504 = 46340
  localparam int unsigned HSQ2_Q16 = 46340;
endpackage

// File: rtl/sdf_span_ctrl.sv
module sdf_span_ctrl #(
  parameter int HALF = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       sof,
  output logic       is_bfly,
  output logic [1:0] quarter,
  output logic       drain_ok
);
  localparam int CW = $clog2(2 * HALF);
  localparam logic [CW-1:0] LAST_POS = CW'(2 * HALF - 1);
  localparam logic [CW-1:0] FILL_END = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          pend_q;
  logic [CW-1:0] pos;

  // effective position of the sample on the input this cycle
  assign pos      = sof ? '0 : cnt_q;
  assign is_bfly  = pos[CW-1];
  assign quarter  = pos[CW-2 -: 2];
  // a strobe that does not land on position 0 breaks the pending drain
  assign drain_ok = pend_q && !(sof && (cnt_q != '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (step) begin
      cnt_q <= pos + 1'b1;
      if (pos == LAST_POS)      pend_q <= 1'b1;
      else if (pos == FILL_END) pend_q <= 1'b0;
      else                      pend_q <= drain_ok;
    end
  end

  AST_SOF_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    step && sof |=> cnt_q == CW'(1)); // R3
endmodule

// File: rtl/sdf_delay.sv
module sdf_delay #(
  parameter int W     = 26,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [DEPTH-1:0][W-1:0] line_q;

  assign dout = line_q[DEPTH-1];

  always_ff @(posedge clk) begin
    if (!rst_n)    line_q <= '0;
    else if (push) line_q <= {line_q[DEPTH-2:0], din};
  end
endmodule

// File: rtl/sdf_trivial_rot.sv
module sdf_trivial_rot
  import sdf_pkg::*;
#(
  parameter int        BW   = 13,
  parameter rot_kind_e KIND = ROT_W8
) (
  input  logic [1:0]           quarter,
  input  logic                 inv,
  input  logic signed [BW-1:0] a_re,
  input  logic signed [BW-1:0] a_im,
  output logic signed [BW-1:0] y_re,
  output logic signed [BW-1:0] y_im
);
  localparam int XW = BW + 2;
  localparam int PW = BW + 18;
  localparam logic signed [XW-1:0] HI = {3'b000, {(BW-1){1'b1}}};
  localparam logic signed [XW-1:0] LO = {3'b111, {(BW-1){1'b0}}};

  // v * 0.1011010100000100b, rounded to nearest (half rounds up)
  function automatic logic signed [XW-1:0] mul_hsq(input logic signed [XW-1:0] v);
    logic signed [PW-1:0] w;
    logic signed [PW-1:0] p;
    w = PW'(v);
    p = (w <<< 15) + (w <<< 13) + (w <<< 12) + (w <<< 10) + (w <<< 8) + (w <<< 2);
    p = p + PW'(32768);
    return XW'(p >>> 16);
  endfunction

  function automatic logic signed [BW-1:0] clip(input logic signed [XW-1:0] v);
    if (v > HI)      return HI[BW-1:0];
    else if (v < LO) return LO[BW-1:0];
    else             return v[BW-1:0];
  endfunction

  logic [1:0] k;

  generate
    if (KIND == ROT_W8) begin : g_w8
      assign k = quarter;
    end else if (KIND == ROT_MJ) begin : g_mj
      assign k = {quarter[1], 1'b0};
    end else begin : g_none
      assign k = 2'd0;
    end
  endgenerate

  logic signed [XW-1:0] ae, be, s_ab, d_ba, d_ab, r_x, i_x;

  always_comb begin
    ae   = XW'(a_re);
    be   = XW'(a_im);
    s_ab = ae + be;
    d_ba = be - ae;
    d_ab = ae - be;
    unique case (k)
      2'd0: begin r_x = ae; i_x = be; end
      2'd1: begin
        if (!inv) begin r_x = mul_hsq(s_ab); i_x = mul_hsq(d_ba); end
        else      begin r_x = mul_hsq(d_ab); i_x = mul_hsq(s_ab); end
      end
      2'd2: begin
        if (!inv) begin r_x = be;  i_x = -ae; end
        else      begin r_x = -be; i_x = ae;  end
      end
      default: begin
        if (!inv) begin r_x = mul_hsq(d_ba);  i_x = -mul_hsq(s_ab); end
        else      begin r_x = -mul_hsq(s_ab); i_x = mul_hsq(d_ab);  end
      end
    endcase
    y_re = clip(r_x);
    y_im = clip(i_x);
  end
endmodule

// File: rtl/sdf_r2cube_stage.sv
module sdf_r2cube_stage
  import sdf_pkg::*;
#(
  parameter int        DW    = 12,
  parameter int        HALF  = 8,
  parameter rot_kind_e KIND  = ROT_W8,
  parameter bit        SCALE = 1'b0
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    i_valid,
  input  logic                                    i_sof,
  input  logic                                    i_inv,
  input  logic                                    i_bypass,
  input  logic signed [DW-1:0]                    i_re,
  input  logic signed [DW-1:0]                    i_im,
  output logic                                    o_valid,
  output logic signed [(SCALE ? DW : DW + 1)-1:0] o_re,
  output logic signed [(SCALE ? DW : DW + 1)-1:0] o_im
);
  localparam int BW = DW + 1;
  localparam int OW = SCALE ? DW : BW;
  localparam int SH = SCALE ? 1 : 0;

  function automatic logic signed [OW-1:0] shrink(input logic signed [BW-1:0] v);
    return OW'(v >>> SH);
  endfunction

  // named internal events
  logic step, is_bfly, drain_ok;
  logic [1:0] quarter;
  assign step = i_valid && !i_bypass;

  sdf_span_ctrl #(.HALF(HALF)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .step(step), .sof(i_sof),
    .is_bfly(is_bfly), .quarter(quarter), .drain_ok(drain_ok)
  );

  logic signed [BW-1:0] x_re, x_im, d_re, d_im;
  logic signed [BW-1:0] sum_re, sum_im, dif_re, dif_im;
  logic signed [BW-1:0] rot_re, rot_im, push_re, push_im;
  logic [2*BW-1:0]      dl_out;

  assign x_re   = BW'(i_re);
  assign x_im   = BW'(i_im);
  assign d_re   = $signed(dl_out[2*BW-1:BW]);
  assign d_im   = $signed(dl_out[BW-1:0]);
  assign sum_re = d_re + x_re;
  assign sum_im = d_im + x_im;
  assign dif_re = d_re - x_re;
  assign dif_im = d_im - x_im;

  assign push_re = is_bfly ? dif_re : x_re;
  assign push_im = is_bfly ? dif_im : x_im;

  sdf_delay #(.W(2 * BW), .DEPTH(HALF)) u_dly (
    .clk(clk), .rst_n(rst_n), .push(step),
    .din({push_re, push_im}), .dout(dl_out)
  );

  sdf_trivial_rot #(.BW(BW), .KIND(KIND)) u_rot (
    .quarter(quarter), .inv(i_inv),
    .a_re(d_re), .a_im(d_im), .y_re(rot_re), .y_im(rot_im)
  );

  logic                 nxt_v;
  logic signed [OW-1:0] nxt_re, nxt_im;

  always_comb begin
    if (i_bypass) begin
      nxt_v  = i_valid;
      nxt_re = OW'(i_re);
      nxt_im = OW'(i_im);
    end else if (is_bfly) begin
      nxt_v  = i_valid;
      nxt_re = shrink(sum_re);
      nxt_im = shrink(sum_im);
    end else begin
      nxt_v  = i_valid && drain_ok;
      nxt_re = shrink(rot_re);
      nxt_im = shrink(rot_im);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_re    <= '0;
      o_im    <= '0;
    end else begin
      o_valid <= nxt_v;
      if (nxt_v) begin
        o_re <= nxt_re;
        o_im <= nxt_im;
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !i_valid |=> !o_valid); // R2
  AST_BYPASS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    i_valid && i_bypass |=> o_valid && o_re == $past(OW'(i_re)) && o_im == $past(OW'(i_im))); // R9
  AST_BFLY_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
    step && is_bfly |=> o_valid); // R4
  AST_UNARMED_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    step && !is_bfly && !drain_ok |=> !o_valid); // R5
endmodule

// File: tb/sim_sdf_r2cube_stage.sv
`timescale 1ns/1ps
module sim_sdf_r2cube_stage;
  import sdf_pkg::*;

  localparam int DW = 12;
  localparam int H  = 8;
  localparam int HI = 4095;
  localparam int LO = -4096;

  localparam int STIM [16][2] = '{
    '{ 312, -1040}, '{-877,   455}, '{1500,   -21}, '{ -64,  2000},
    '{ 900,   901}, '{-2048,  777}, '{ 133, -1999}, '{2047,  -300},
    '{ -15,    16}, '{ 640,  -640}, '{-1234, 1111}, '{  70,  1800},
    '{1024, -1024}, '{-500,  -501}, '{ 256,  1792}, '{ -900,   33}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic i_valid = 1'b0, i_sof = 1'b0, i_inv = 1'b0, i_bypass = 1'b0;
  logic signed [DW-1:0] i_re = '0, i_im = '0;
  logic o_valid0, o_valid1;
  logic signed [DW:0]   o_re0, o_im0;
  logic signed [DW-1:0] o_re1, o_im1;

  always #4 clk = ~clk;

  sdf_r2cube_stage #(.DW(DW), .HALF(H), .KIND(ROT_W8), .SCALE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_sof(i_sof), .i_inv(i_inv),
    .i_bypass(i_bypass), .i_re(i_re), .i_im(i_im),
    .o_valid(o_valid0), .o_re(o_re0), .o_im(o_im0));

  sdf_r2cube_stage #(.DW(DW), .HALF(H), .KIND(ROT_MJ), .SCALE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_sof(i_sof), .i_inv(i_inv),
    .i_bypass(i_bypass), .i_re(i_re), .i_im(i_im),
    .o_valid(o_valid1), .o_re(o_re1), .o_im(o_im1));

  int nchk = 0, nerr = 0;
  bit done = 0;
  int m_pos = 0;
  bit m_pend = 0;
  int fst_re[H], fst_im[H], dif_re[H], dif_im[H];

  task automatic chk(string tag, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int hsq(int v);
    return (v * 46340 + 32768) >>> 16;
  endfunction

  function automatic int clampv(int v);
    return (v > HI) ? HI : ((v < LO) ? LO : v);
  endfunction

  // kind 2 = eighth-circle set, kind 1 = -j only
  function automatic void rot_ref(int kind, int q, bit inv, int a, int b,
                                  output int r, output int i);
    int k;
    k = (kind == 2) ? q / (H / 4) : ((q >= H / 2) ? 2 : 0);
    case (k)
      0: begin r = a; i = b; end
      1: if (!inv) begin r = hsq(a + b); i = hsq(b - a); end
         else      begin r = hsq(a - b); i = hsq(a + b); end
      2: if (!inv) begin r = b;  i = -a; end
         else      begin r = -b; i = a;  end
      default: if (!inv) begin r = hsq(b - a);  i = -hsq(a + b); end
               else      begin r = -hsq(a + b); i = hsq(a - b);  end
    endcase
  endfunction

  task automatic send(int re, int im, bit sof, bit inv, bit byp, string vtag);
    bit ev;
    int e0r, e0i, e1r, e1i, p, q, rr, ri;
    string t0, t1;
    if (byp) begin
      ev = 1; e0r = re; e0i = im; e1r = re; e1i = im; t0 = "R9"; t1 = "R9";
    end else begin
      p = sof ? 0 : m_pos;
      if (sof && m_pos != 0) m_pend = 0;
      if (p < H) begin
        ev = m_pend;
        rot_ref(2, p, inv, dif_re[p], dif_im[p], rr, ri);
        e0r = clampv(rr); e0i = clampv(ri);
        t0 = (e0r != rr || e0i != ri) ? "R8" : (inv ? "R7" : "R6");
        rot_ref(1, p, inv, dif_re[p], dif_im[p], rr, ri);
        e1r = clampv(rr) >>> 1; e1i = clampv(ri) >>> 1; t1 = "R12";
        fst_re[p] = re; fst_im[p] = im;
        if (p == H - 1) m_pend = 0;
      end else begin
        q = p - H;
        ev = 1;
        e0r = fst_re[q] + re; e0i = fst_im[q] + im;
        e1r = e0r >>> 1; e1i = e0i >>> 1;
        dif_re[q] = fst_re[q] - re; dif_im[q] = fst_im[q] - im;
        t0 = "R4"; t1 = "R10";
        if (p == 2 * H - 1) m_pend = 1;
      end
      m_pos = (p + 1) % (2 * H);
    end
    i_valid = 1; i_sof = sof; i_inv = inv; i_bypass = byp;
    i_re = DW'(re); i_im = DW'(im);
    @(posedge clk);
    @(negedge clk);
    if (vtag != "") begin
      chk(vtag, "o_valid u0", int'(o_valid0), int'(ev));
      chk(vtag, "o_valid u1", int'(o_valid1), int'(ev));
    end else begin
      chk(ev ? t0 : "R5", "o_valid u0", int'(o_valid0), int'(ev));
      chk(ev ? t1 : "R5", "o_valid u1", int'(o_valid1), int'(ev));
    end
    if (ev) begin
      chk(t0, "o_re u0", int'(o_re0), e0r);
      chk(t0, "o_im u0", int'(o_im0), e0i);
      chk(t1, "o_re u1", int'(o_re1), e1r);
      chk(t1, "o_im u1", int'(o_im1), e1i);
    end
    i_valid = 0; i_sof = 0; i_bypass = 0;
  endtask

  task automatic idle_cycle();
    i_valid = 0;
    @(posedge clk);
    @(negedge clk);
    chk("R2", "o_valid u0 idle", int'(o_valid0), 0);
    chk("R2", "o_valid u1 idle", int'(o_valid1), 0);
  endtask

  function automatic int g_re(int f, int i);
    return STIM[(i + 5 * f) % 16][0];
  endfunction
  function automatic int g_im(int f, int i);
    return STIM[(i + 3 * f) % 16][1];
  endfunction

  task automatic frame(int f, bit inv);
    for (int i = 0; i < 16; i++) begin
      send(g_re(f, i), g_im(f, i), i == 0, inv, 0, (i == 0 && f == 0) ? "R3" : "");
      if (f == 1 && i == 7) idle_cycle();
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1", "o_valid u0 reset", int'(o_valid0), 0);
    chk("R1", "o_re u0 reset", int'(o_re0), 0);
    chk("R1", "o_im u0 reset", int'(o_im0), 0);
    chk("R1", "o_valid u1 reset", int'(o_valid1), 0);
    rst_n = 1;
    idle_cycle();
    idle_cycle();
    frame(0, 0);
    frame(1, 0);
    frame(2, 0);
    frame(3, 1);
    // saturation setup: pairs 2,3 give +4095 differences, pairs 6,7 give -4095
    for (int i = 0; i < 16; i++) begin
      int vr, vi;
      vr = g_re(4, i); vi = g_im(4, i);
      if (i == 2 || i == 3)   begin vr = 2047;  vi = 2047;  end
      if (i == 10 || i == 11) begin vr = -2048; vi = -2048; end
      if (i == 6 || i == 7)   begin vr = -2048; vi = -2048; end
      if (i == 14 || i == 15) begin vr = 2047;  vi = 2047;  end
      send(vr, vi, i == 0, 0, 0, "");
    end
    // drain with saturation, and bypass samples slipped in mid-span
    for (int i = 0; i < 16; i++) begin
      if (i == 4) begin
        send(-2048, 2047, 1, 0, 1, "R9");
        send(1234, -7, 0, 1, 1, "R9");
      end
      send(g_re(5, i), g_im(5, i), i == 0, 0, 0, "");
    end
    // misaligned frame start at position 5 cancels the drain
    for (int i = 0; i < 5; i++) send(g_re(6, i), g_im(6, i), i == 0, 1, 0, "");
    for (int i = 0; i < 16; i++)
      send(g_re(7, i), g_im(7, i), i == 0, 1, 0, (i < 8) ? "R11" : "R3");
    frame(8, 1);
    frame(9, 0);
    idle_cycle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule